// File: doc/BRIEF.md
# Bus Error Exception Controller

This block sits beside the bus interface of a 32-bit processor and decides what an aborted bus cycle turns into. Each completed cycle is reported with its kind: a data access, an instruction prefetch carrying a small tag, or one beat of a burst. The block then either raises a bus error exception right away, holds the fault until the prefetched word is really used, or only cuts the burst short. It also handles misses in the address translation cache. A miss cancels the external cycle and requests a table search. Any fault found during that search is held, and it is reported when the original cycle is retried.

On top of that classification the block detects a double fault. A bus error or an address error that arrives while exception processing is already under way stops the machine. The block then holds a halt state with a status line that stays asserted. A software reset command drives the external reset line for a fixed number of cycles. It raises no exception and leaves the held fault state untouched. The synchronous reset input is the only way out of the halt state, and it clears every held fault. All outputs are registered, so each one responds on the clock edge after the inputs that caused it.

Top module: `buserr_ctrl`

## Requirements
- R1: An aborted data-access cycle (kind 0, or the reserved kind 3) outside exception processing gives a one-cycle exc_req_o with cause_o = 1 on the next edge.
- R2: An aborted prefetch (kind 1) marks its tag as faulty and raises nothing at first. A later consume_i carrying that tag gives exc_req_o with cause_o = 2, once only. A consume of a tag that was never marked does nothing, and a clean prefetch that reuses a tag clears the mark.
- R3: An abort on burst beat 1, 2 or 3 (kind 2) gives a one-cycle burst_abort_o and no exception. An abort on beat 0 counts as a data-access fault (cause 1).
- R4: A cycle end with atc_miss_i pulses walk_start_o on the next edge, and any abort on that same cycle is ignored. After walk_done_i with no fault flags, retry_o pulses one edge later with no exception.
- R5: walk_limit_i or walk_invalid_i at walk_done_i, or walk_berr_i at any point during the search, makes the retry carry exc_req_o with cause_o = 3 in the same cycle as retry_o.
- R6: A data-access fault wins over a coinciding retry or prefetch consume. The retry waits one cycle, and the prefetch fault stays marked for its next consume.
- R7: flush_i discards every marked prefetch fault, so a later consume of a discarded tag raises nothing.
- R8: sw_reset_i holds ext_reset_o high for exactly 124 consecutive cycles, starting on the next edge. It raises no exception and keeps the marked faults. The command is ignored while the pulse is active or while the block is halted.
- R9: An abort (other than burst beats 1 to 3) or addr_err_i while in_exc_i is high sets halt_o and status_o, and both stay high. While halted, no exception, burst abort, walk start or retry is produced.
- R10: rst is the only exit from the halt state. It clears all outputs and every marked or held fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high external reset |
| cyc_end_i | input | 1 | A bus cycle completes this clock |
| cyc_kind_i | input | 2 | 0 data, 1 prefetch, 2 burst beat, 3 treated as data |
| beat_i | input | BEAT_W | Burst beat index |
| pf_tag_i | input | TAG_W | Tag of a prefetch cycle |
| abort_i | input | 1 | External bus error abort on the completing cycle |
| atc_miss_i | input | 1 | The completing cycle missed the translation cache |
| consume_i | input | 1 | A prefetched word is being used |
| cons_tag_i | input | TAG_W | Tag of the used prefetch |
| flush_i | input | 1 | Prefetched words are discarded |
| walk_done_i | input | 1 | Table search finished |
| walk_limit_i | input | 1 | Search hit a limit violation (with done) |
| walk_invalid_i | input | 1 | Search found an invalid descriptor (with done) |
| walk_berr_i | input | 1 | A search access was aborted |
| in_exc_i | input | 1 | Exception processing for a bus error, address error or reset is in progress |
| addr_err_i | input | 1 | Address error detected |
| sw_reset_i | input | 1 | Software reset command |
| exc_req_o | output | 1 | Bus error exception request pulse |
| cause_o | output | 2 | 1 data, 2 prefetch, 3 translation; valid with exc_req_o |
| burst_abort_o | output | 1 | Burst cut short pulse |
| walk_start_o | output | 1 | Start table search pulse |
| retry_o | output | 1 | Retry the cycle that missed |
| halt_o | output | 1 | Halted after a double fault |
| status_o | output | 1 | Status line, held high while halted |
| ext_reset_o | output | 1 | External reset drive |

## Verification
The properties assume that a table search is only under way after a miss, so walk_done_i and walk_berr_i arrive only between a walk start and the retry. They also assume that no new miss is reported while a search is running. The bench keeps to this by driving each search as a fixed sequence of miss, optional search fault, done and a retry cycle. It also assumes that in_exc_i and addr_err_i are raised only in the cycles that test the double fault, and the bench holds them low everywhere else. Reset is applied only where the stimulus means to leave the halt state.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_PREF  = 2'd1,
    KIND_BURST = 2'd2,
    KIND_RSVD  = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_DATA  = 2'd1,
    CAUSE_PREF  = 2'd2,
    CAUSE_XLATE = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_WALK  = 2'd1,
    XS_RETRY = 2'd2
  } xlate_state_e;

  typedef struct packed {
    logic data_fault;
    logic pf_fault;
    logic pf_clean;
    logic burst_cut;
    logic miss;
    logic dbl;
  } class_t;
endpackage

// File: rtl/buserr_classify.sv
module buserr_classify
  import buserr_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              cyc_end,
  input  logic [1:0]        kind,
  input  logic [BEAT_W-1:0] beat,
  input  logic              abort,
  input  logic              atc_miss,
  input  logic              in_exc,
  input  logic              addr_err,
  input  logic              halted,
  input  logic              walk_busy,
  output class_t            cls
);
  logic live, aborted, later_beat, is_pref, is_dataish;

  always_comb begin
    live       = cyc_end & ~halted;
    is_pref    = (kind == KIND_PREF);
    later_beat = (kind == KIND_BURST) && (beat != '0);
    is_dataish = (kind == KIND_DATA) || (kind == KIND_RSVD) ||
                 ((kind == KIND_BURST) && (beat == '0));
    // A miss cancels the external cycle, so its abort is not a bus error.
    aborted    = live & abort & ~atc_miss;

    cls.miss       = live & atc_miss & ~walk_busy;
    cls.data_fault = aborted & ~in_exc & is_dataish;
    cls.pf_fault   = aborted & ~in_exc & is_pref;
    cls.pf_clean   = live & ~abort & ~atc_miss & is_pref;
    cls.burst_cut  = aborted & later_beat;
    cls.dbl        = ~halted & in_exc & ((aborted & ~later_beat) | addr_err);
  end
endmodule

// File: rtl/buserr_pf_track.sv
module buserr_pf_track #(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic             clean,
  input  logic [TAG_W-1:0] cyc_tag,
  input  logic             consume,
  input  logic [TAG_W-1:0] cons_tag,
  input  logic             flush,
  input  logic             blocked,
  input  logic             halted,
  output logic             fire
);
  localparam int NTAGS = 1 << TAG_W;

  logic [NTAGS-1:0] pend_q;

  assign fire = consume & ~halted & ~blocked & pend_q[cons_tag];

  for (genvar i = 0; i < NTAGS; i++) begin : g_slot
    logic hit_cyc, hit_use;
    assign hit_cyc = (cyc_tag == TAG_W'(i));
    assign hit_use = fire && (cons_tag == TAG_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
      end else if (set && hit_cyc) begin
        pend_q[i] <= 1'b1;
      end else if ((flush && !halted) || (clean && hit_cyc) || hit_use) begin
        pend_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/buserr_xlate.sv
module buserr_xlate
  import buserr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic miss,
  input  logic walk_done,
  input  logic walk_limit,
  input  logic walk_invalid,
  input  logic walk_berr,
  input  logic hold,
  input  logic halted,
  output logic busy,
  output logic retry_fire,
  output logic exc_fire
);
  xlate_state_e state_q;
  logic         fault_q;

  assign busy       = (state_q != XS_IDLE);
  assign retry_fire = (state_q == XS_RETRY) & ~hold & ~halted;
  assign exc_fire   = retry_fire & fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XS_IDLE;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        XS_IDLE: begin
          if (miss) begin
            state_q <= XS_WALK;
            fault_q <= 1'b0;
          end
        end
        XS_WALK: begin
          if (walk_done) begin
            fault_q <= fault_q | walk_limit | walk_invalid | walk_berr;
            state_q <= XS_RETRY;
          end else if (walk_berr) begin
            fault_q <= 1'b1;
          end
        end
        XS_RETRY: begin
          if (retry_fire) state_q <= XS_IDLE;
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/buserr_rst_timer.sv
module buserr_rst_timer #(
  parameter int CYCLES = 124
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      left_q <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        left_q <= CNT_W'(CYCLES - 1);
      end
    end else if (left_q == '0) begin
      active <= 1'b0;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/buserr_ctrl.sv
module buserr_ctrl
  import buserr_pkg::*;
#(
  parameter int TAG_W      = 3,
  parameter int BEAT_W     = 2,
  parameter int RST_CYCLES = 124
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_end_i,
  input  logic [1:0]        cyc_kind_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [TAG_W-1:0]  pf_tag_i,
  input  logic              abort_i,
  input  logic              atc_miss_i,
  input  logic              consume_i,
  input  logic [TAG_W-1:0]  cons_tag_i,
  input  logic              flush_i,
  input  logic              walk_done_i,
  input  logic              walk_limit_i,
  input  logic              walk_invalid_i,
  input  logic              walk_berr_i,
  input  logic              in_exc_i,
  input  logic              addr_err_i,
  input  logic              sw_reset_i,
  output logic              exc_req_o,
  output logic [1:0]        cause_o,
  output logic              burst_abort_o,
  output logic              walk_start_o,
  output logic              retry_o,
  output logic              halt_o,
  output logic              status_o,
  output logic              ext_reset_o
);
  class_t cls;
  logic   walk_busy, x_retry, x_exc, pf_fire;
  logic   halted_q;

  buserr_classify #(.BEAT_W(BEAT_W)) u_cls (
    .cyc_end   (cyc_end_i),
    .kind      (cyc_kind_i),
    .beat      (beat_i),
    .abort     (abort_i),
    .atc_miss  (atc_miss_i),
    .in_exc    (in_exc_i),
    .addr_err  (addr_err_i),
    .halted    (halted_q),
    .walk_busy (walk_busy),
    .cls       (cls)
  );

  buserr_xlate u_xl (
    .clk          (clk),
    .rst          (rst),
    .miss         (cls.miss),
    .walk_done    (walk_done_i),
    .walk_limit   (walk_limit_i),
    .walk_invalid (walk_invalid_i),
    .walk_berr    (walk_berr_i),
    .hold         (cls.data_fault),
    .halted       (halted_q),
    .busy         (walk_busy),
    .retry_fire   (x_retry),
    .exc_fire     (x_exc)
  );

  buserr_pf_track #(.TAG_W(TAG_W)) u_pf (
    .clk      (clk),
    .rst      (rst),
    .set      (cls.pf_fault),
    .clean    (cls.pf_clean),
    .cyc_tag  (pf_tag_i),
    .consume  (consume_i),
    .cons_tag (cons_tag_i),
    .flush    (flush_i),
    .blocked  (cls.data_fault | x_exc),
    .halted   (halted_q),
    .fire     (pf_fire)
  );

  buserr_rst_timer #(.CYCLES(RST_CYCLES)) u_rt (
    .clk    (clk),
    .rst    (rst),
    .start  (sw_reset_i & ~halted_q),
    .active (ext_reset_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q      <= 1'b0;
      status_o      <= 1'b0;
      exc_req_o     <= 1'b0;
      cause_o       <= CAUSE_NONE;
      burst_abort_o <= 1'b0;
      walk_start_o  <= 1'b0;
      retry_o       <= 1'b0;
    end else begin
      halted_q      <= halted_q | cls.dbl;
      status_o      <= halted_q | cls.dbl;
      exc_req_o     <= ~cls.dbl & (cls.data_fault | x_exc | pf_fire);
      burst_abort_o <= cls.burst_cut;
      walk_start_o  <= cls.miss;
      retry_o       <= x_retry;
      if (cls.data_fault)  cause_o <= CAUSE_DATA;
      else if (x_exc)      cause_o <= CAUSE_XLATE;
      else if (pf_fire)    cause_o <= CAUSE_PREF;
      else                 cause_o <= CAUSE_NONE;
    end
  end

  assign halt_o = halted_q;
endmodule

// File: rtl/buserr_ctrl_chk.sv
module buserr_ctrl_chk #(
  parameter int BEAT_W     = 2,
  parameter int RST_CYCLES = 124
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_end_i,
  input logic [1:0]        cyc_kind_i,
  input logic [BEAT_W-1:0] beat_i,
  input logic              abort_i,
  input logic              atc_miss_i,
  input logic              in_exc_i,
  input logic              exc_req_o,
  input logic [1:0]        cause_o,
  input logic              burst_abort_o,
  input logic              walk_start_o,
  input logic              retry_o,
  input logic              halt_o,
  input logic              status_o,
  input logic              ext_reset_o
);
  localparam int HW = $clog2(RST_CYCLES + 1) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)              hi_cnt <= '0;
    else if (ext_reset_o) hi_cnt <= hi_cnt + 1'b1;
    else                  hi_cnt <= '0;
  end

  a_r1_data_exc: assert property (@(posedge clk) disable iff (rst)
    (cyc_end_i && abort_i && !atc_miss_i && cyc_kind_i == 2'd0 && !in_exc_i && !halt_o)
    |=> (exc_req_o && cause_o == 2'd1));

  a_r3_burst_cut: assert property (@(posedge clk) disable iff (rst)
    (cyc_end_i && abort_i && !atc_miss_i && cyc_kind_i == 2'd2 && beat_i != '0 && !halt_o)
    |=> burst_abort_o);

  a_r3_no_data_exc: assert property (@(posedge clk) disable iff (rst)
    burst_abort_o |-> !(exc_req_o && cause_o == 2'd1));

  a_r4_no_retry_at_start: assert property (@(posedge clk) disable iff (rst)
    walk_start_o |=> !retry_o);

  a_r5_xlate_with_retry: assert property (@(posedge clk) disable iff (rst)
    (exc_req_o && cause_o == 2'd3) |-> retry_o);

  a_r8_len_max: assert property (@(posedge clk) disable iff (rst)
    ext_reset_o |-> (hi_cnt < HW'(RST_CYCLES)));

  a_r8_len_full: assert property (@(posedge clk) disable iff (rst)
    ($fell(ext_reset_o) && !$past(rst)) |-> (hi_cnt == HW'(RST_CYCLES)));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt_o |=> halt_o);

  a_r9_status_held: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> status_o);

  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    halt_o |=> (!exc_req_o && !walk_start_o && !retry_o && !burst_abort_o));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!halt_o && !exc_req_o && !ext_reset_o && !retry_o));
endmodule

bind buserr_ctrl buserr_ctrl_chk #(.BEAT_W(BEAT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cyc_end_i     (cyc_end_i),
  .cyc_kind_i    (cyc_kind_i),
  .beat_i        (beat_i),
  .abort_i       (abort_i),
  .atc_miss_i    (atc_miss_i),
  .in_exc_i      (in_exc_i),
  .exc_req_o     (exc_req_o),
  .cause_o       (cause_o),
  .burst_abort_o (burst_abort_o),
  .walk_start_o  (walk_start_o),
  .retry_o       (retry_o),
  .halt_o        (halt_o),
  .status_o      (status_o),
  .ext_reset_o   (ext_reset_o)
);

// File: tb/sim_buserr_ctrl.sv
module sim_buserr_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, cyc_end, abort, miss, consume, flush, wdone, wlim, winv, wberr;
  logic       in_exc, aerr, swrst;
  logic [1:0] kind, beat;
  logic [2:0] ptag, ctag;
  logic       exc_req, burst_abort, walk_start, retry, halt, status, ext_reset;
  logic [1:0] cause;

  buserr_ctrl u0 (
    .clk(clk), .rst(rst), .cyc_end_i(cyc_end), .cyc_kind_i(kind), .beat_i(beat),
    .pf_tag_i(ptag), .abort_i(abort), .atc_miss_i(miss), .consume_i(consume),
    .cons_tag_i(ctag), .flush_i(flush), .walk_done_i(wdone), .walk_limit_i(wlim),
    .walk_invalid_i(winv), .walk_berr_i(wberr), .in_exc_i(in_exc), .addr_err_i(aerr),
    .sw_reset_i(swrst), .exc_req_o(exc_req), .cause_o(cause), .burst_abort_o(burst_abort),
    .walk_start_o(walk_start), .retry_o(retry), .halt_o(halt), .status_o(status),
    .ext_reset_o(ext_reset)
  );

  // staged stimulus for the next tick
  logic       s_rst, s_end, s_abort, s_miss, s_cons, s_flush, s_done, s_lim, s_inv, s_wberr;
  logic       s_inexc, s_aerr, s_sw;
  logic [1:0] s_kind, s_beat;
  logic [2:0] s_ptag, s_ctag;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  int         checks = 0, fails = 0;
  bit         done = 0;

  function automatic logic [8:0] ex(input logic e, input logic [1:0] c, input logic b,
                                    input logic w, input logic r, input logic h, input logic x);
    return {e, c, b, w, r, h, h, x};
  endfunction

  task automatic clear_stage();
    s_rst = 0; s_end = 0; s_abort = 0; s_miss = 0; s_cons = 0; s_flush = 0; s_done = 0;
    s_lim = 0; s_inv = 0; s_wberr = 0; s_inexc = 0; s_aerr = 0; s_sw = 0;
    s_kind = 0; s_beat = 0; s_ptag = 0; s_ctag = 0;
  endtask

  // driver: apply staged inputs and push the outputs expected after the next edge
  task automatic tick(input logic [8:0] e, input string t);
    @(negedge clk);
    rst = s_rst; cyc_end = s_end; abort = s_abort; miss = s_miss; consume = s_cons;
    flush = s_flush; wdone = s_done; wlim = s_lim; winv = s_inv; wberr = s_wberr;
    in_exc = s_inexc; aerr = s_aerr; swrst = s_sw; kind = s_kind; beat = s_beat;
    ptag = s_ptag; ctag = s_ctag;
    exp_q.push_back(e);
    tag_q.push_back(t);
    clear_stage();
  endtask

  task automatic cyc(input logic [1:0] k, input logic [1:0] b, input logic [2:0] t, input logic ab);
    s_end = 1; s_kind = k; s_beat = b; s_ptag = t; s_abort = ab;
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [8:0] e, o;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      o = {exc_req, cause, burst_abort, walk_start, retry, halt, status, ext_reset};
      checks++;
      if (o !== e) begin
        fails++;
        $display("FAIL %s: got %b expected %b", t, o, e);
      end
    end
  end

  localparam logic [8:0] Z = 9'b0;

  initial begin
    clear_stage();
    rst = 1; cyc_end = 0; abort = 0; miss = 0; consume = 0; flush = 0; wdone = 0;
    wlim = 0; winv = 0; wberr = 0; in_exc = 0; aerr = 0; swrst = 0; kind = 0; beat = 0;
    ptag = 0; ctag = 0;
    repeat (3) @(negedge clk);
    tick(Z, "R10 reset state");

    // R1 data fault
    cyc(0, 0, 0, 1); tick(ex(1, 1, 0, 0, 0, 0, 0), "R1 data abort");
    tick(Z, "R1 single pulse");
    cyc(3, 0, 0, 1); tick(ex(1, 1, 0, 0, 0, 0, 0), "R1 reserved kind as data");

    // R2 prefetch deferral
    cyc(1, 0, 2, 1); tick(Z, "R2 prefetch abort deferred");
    s_cons = 1; s_ctag = 5; tick(Z, "R2 other tag");
    s_cons = 1; s_ctag = 2; tick(ex(1, 2, 0, 0, 0, 0, 0), "R2 consume faulty tag");
    s_cons = 1; s_ctag = 2; tick(Z, "R2 once only");
    cyc(1, 0, 6, 1); tick(Z, "R2 abort tag6");
    cyc(1, 0, 6, 0); tick(Z, "R2 clean reuse");
    s_cons = 1; s_ctag = 6; tick(Z, "R2 cleared by clean prefetch");

    // R3 burst
    cyc(2, 2, 0, 1); tick(ex(0, 0, 1, 0, 0, 0, 0), "R3 beat 2 abort");
    cyc(2, 3, 0, 1); tick(ex(0, 0, 1, 0, 0, 0, 0), "R3 beat 3 abort");
    cyc(2, 0, 0, 1); tick(ex(1, 1, 0, 0, 0, 0, 0), "R3 beat 0 is data");

    // R4 clean search
    cyc(0, 0, 0, 1); s_miss = 1; tick(ex(0, 0, 0, 1, 0, 0, 0), "R4 miss starts walk");
    tick(Z, "R4 walking");
    s_done = 1; tick(Z, "R4 done");
    tick(ex(0, 0, 0, 0, 1, 0, 0), "R4 retry no exc");
    tick(Z, "R4 idle");

    // R5 search faults
    cyc(0, 0, 0, 0); s_miss = 1; tick(ex(0, 0, 0, 1, 0, 0, 0), "R5 miss");
    s_wberr = 1; tick(Z, "R5 walk bus error held");
    s_done = 1; tick(Z, "R5 done");
    tick(ex(1, 3, 0, 0, 1, 0, 0), "R5 walk berr on retry");
    cyc(0, 0, 0, 0); s_miss = 1; tick(ex(0, 0, 0, 1, 0, 0, 0), "R5 miss 2");
    s_done = 1; s_lim = 1; tick(Z, "R5 limit");
    tick(ex(1, 3, 0, 0, 1, 0, 0), "R5 limit on retry");

    // R6 priority
    cyc(1, 0, 1, 1); tick(Z, "R6 pf abort tag1");
    cyc(0, 0, 0, 1); s_cons = 1; s_ctag = 1; tick(ex(1, 1, 0, 0, 0, 0, 0), "R6 data wins consume");
    s_cons = 1; s_ctag = 1; tick(ex(1, 2, 0, 0, 0, 0, 0), "R6 prefetch kept");
    cyc(0, 0, 0, 0); s_miss = 1; tick(ex(0, 0, 0, 1, 0, 0, 0), "R6 miss");
    s_done = 1; s_inv = 1; tick(Z, "R6 invalid");
    cyc(0, 0, 0, 1); tick(ex(1, 1, 0, 0, 0, 0, 0), "R6 data wins retry");
    tick(ex(1, 3, 0, 0, 1, 0, 0), "R6 retry one later");

    // R7 flush
    cyc(1, 0, 3, 1); tick(Z, "R7 pf abort tag3");
    s_flush = 1; tick(Z, "R7 flush");
    s_cons = 1; s_ctag = 3; tick(Z, "R7 discarded");

    // R8 software reset
    cyc(1, 0, 4, 1); tick(Z, "R8 pf abort tag4");
    s_sw = 1; tick(ex(0, 0, 0, 0, 0, 0, 1), "R8 ext reset first cycle");
    for (int i = 1; i < 124; i++) begin
      if (i == 50) s_sw = 1;
      tick(ex(0, 0, 0, 0, 0, 0, 1), "R8 ext reset held");
    end
    tick(Z, "R8 ext reset ends after 124");
    s_cons = 1; s_ctag = 4; tick(ex(1, 2, 0, 0, 0, 0, 0), "R8 state kept over sw reset");

    // R9 double fault
    cyc(1, 0, 5, 1); tick(Z, "R9 pf abort tag5");
    cyc(0, 0, 0, 1); s_inexc = 1; tick(ex(0, 0, 0, 0, 0, 1, 0), "R9 double fault halts");
    tick(ex(0, 0, 0, 0, 0, 1, 0), "R9 status held");
    cyc(0, 0, 0, 1); tick(ex(0, 0, 0, 0, 0, 1, 0), "R9 no exc while halted");
    s_cons = 1; s_ctag = 5; tick(ex(0, 0, 0, 0, 0, 1, 0), "R9 no prefetch exc halted");
    s_sw = 1; tick(ex(0, 0, 0, 0, 0, 1, 0), "R9 sw reset ignored halted");
    cyc(0, 0, 0, 0); s_miss = 1; tick(ex(0, 0, 0, 0, 0, 1, 0), "R9 no walk halted");

    // R10 reset exit
    s_rst = 1; tick(Z, "R10 reset leaves halt");
    s_cons = 1; s_ctag = 5; tick(Z, "R10 pending cleared");
    s_inexc = 1; s_aerr = 1; tick(ex(0, 0, 0, 0, 0, 1, 0), "R9 address error double fault");
    s_rst = 1; tick(Z, "R10 reset again");
    cyc(0, 0, 0, 1); tick(ex(1, 1, 0, 0, 0, 0, 0), "R10 normal after reset");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule